// File: doc/BRIEF.md
# Full/Empty Tagged Synchronizing Memory

This block is a small word-addressed memory where every data word has a one-bit presence tag: 0 means empty, 1 means full. Besides ordinary reads and writes, it carries out synchronizing accesses that test the tag and then update it. A producer deposits a value only into an empty slot and marks the slot full. A consumer takes a value only from a full slot and marks the slot empty. When a synchronizing access cannot proceed, the block either raises a trap flag so software can retry, or, for the probe forms, clears a status bit.

The memory accepts at most one request per clock. Each request is handled in a single read-modify-write pass, so no other access can fall between the tag test and the tag update. The response comes back in the cycle after the request. It carries the word and the tag as they were before the access, a trap flag and a success bit.

Top module: `fetag_mem`

## Requirements
- R1: Reset sets every tag to empty (0) and leaves no response pending. Data words are not initialised by reset.
- R2: A request that is valid at a clock edge produces exactly one response with rspValid high in the following cycle. rspValid stays low in any cycle after an edge with no valid request.
- R3: Plain load (opcode 0) returns the word and its tag, changes nothing, and reports rspOk=1, rspTrap=0.
- R4: Plain store (opcode 1) writes the data, leaves the tag unchanged, and reports rspOk=1, rspTrap=0.
- R5: Put (opcode 3, probe form 5) on an empty word writes the data, sets the tag to full and reports rspOk=1.
- R6: Put on a full word writes nothing, keeps the tag full and fails.
- R7: Take (opcode 2, probe form 4) on a full word returns the data, clears the tag to empty and reports rspOk=1.
- R8: Take on an empty word fails and leaves the tag empty.
- R9: Check-empty load (opcode 6, probe form 7) returns the data with rspOk=1 when the tag is empty, fails when the tag is full, and never changes the tag.
- R10: A failure of a trapping form (opcodes 2, 3, 6) gives rspTrap=1, rspOk=0. A failure of a probe form (opcodes 4, 5, 7) gives rspTrap=0, rspOk=0. rspTrap and rspOk are never both 1.
- R11: Back-to-back requests to the same word see each other's effects in request order. For example, two consecutive puts to one empty word: the first succeeds and the second fails.
- R12: rspData and rspTag always hold the word contents and the tag as they were before the access, for every opcode, including failed ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| reqValid | input | 1 | A request is presented this cycle |
| reqOp | input | 3 | Opcode 0..7 as in R3 to R10 |
| reqAddr | input | ADDR_W | Word address |
| reqWdata | input | DATA_W | Store data |
| rspValid | output | 1 | Response valid, one cycle after the request |
| rspData | output | DATA_W | Word contents before the access |
| rspTag | output | 1 | Tag before the access |
| rspTrap | output | 1 | Trapping form failed |
| rspOk | output | 1 | Operation succeeded |

## Verification
The hardest case to reach is a chain of tagged accesses to one word on consecutive cycles, where each outcome depends on the tag left by the one before. This is where the read-modify-write atomicity either holds or breaks. The stimulus table issues requests back-to-back with no idle cycles, so put, failed put, probe, take and check-empty run into each other on the same address. Plain loads placed between them read back the tag and show that failed accesses changed nothing. A reset in the middle of the run, applied while a word is full, shows that the tags clear again.

// File: rtl/fetag_pkg.sv
package fetag_pkg;

  typedef enum logic [2:0] {
    OP_LOAD        = 3'd0,
    OP_STORE       = 3'd1,
    OP_TAKE        = 3'd2,
    OP_PUT         = 3'd3,
    OP_TAKE_PROBE  = 3'd4,
    OP_PUT_PROBE   = 3'd5,
    OP_CHKE        = 3'd6,
    OP_CHKE_PROBE  = 3'd7
  } feOp_e;

  // strobes from control to datapath
  typedef struct packed {
    logic writeWord;
    logic setTag;
    logic clrTag;
    logic fail;
    logic raiseTrap;
  } feStrobe_t;

endpackage

// File: rtl/fetag_ctrl.sv
module fetag_ctrl
  import fetag_pkg::*;
(
  input  logic       reqValid,
  input  logic [2:0] reqOp,
  input  logic       curTag,
  output feStrobe_t  strb
);

  feOp_e opDec;
  logic  probeForm;

  assign opDec     = feOp_e'(reqOp);
  assign probeForm = (opDec == OP_TAKE_PROBE) || (opDec == OP_PUT_PROBE) ||
                     (opDec == OP_CHKE_PROBE);

  always_comb begin
    strb = '0;
    if (reqValid) begin
      unique case (opDec)
        OP_LOAD: ;
        OP_STORE: strb.writeWord = 1'b1;
        OP_TAKE, OP_TAKE_PROBE: begin
          if (curTag) strb.clrTag = 1'b1;
          else        strb.fail   = 1'b1;
        end
        OP_PUT, OP_PUT_PROBE: begin
          if (!curTag) begin
            strb.writeWord = 1'b1;
            strb.setTag    = 1'b1;
          end else begin
            strb.fail = 1'b1;
          end
        end
        OP_CHKE, OP_CHKE_PROBE: begin
          if (curTag) strb.fail = 1'b1;
        end
        default: ;
      endcase
      strb.raiseTrap = strb.fail && !probeForm;
    end
  end

endmodule

// File: rtl/fetag_dpath.sv
module fetag_dpath
  import fetag_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reqValid,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  input  feStrobe_t         strb,
  output logic              curTag,
  output logic              rspValid,
  output logic [DATA_W-1:0] rspData,
  output logic              rspTag,
  output logic              rspTrap,
  output logic              rspOk
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] words [DEPTH];
  logic              tags  [DEPTH];
  logic [DATA_W-1:0] rdWord;

  assign rdWord = words[reqAddr];
  assign curTag = tags[reqAddr];

  always_ff @(posedge clk) begin
    if (strb.writeWord) words[reqAddr] <= reqWdata;
  end

  for (genvar g = 0; g < DEPTH; g++) begin : gTag
    always_ff @(posedge clk) begin
      if (rst) begin
        tags[g] <= 1'b0;
      end else if (reqAddr == ADDR_W'(g)) begin
        if (strb.setTag)      tags[g] <= 1'b1;
        else if (strb.clrTag) tags[g] <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rspValid <= 1'b0;
      rspData  <= '0;
      rspTag   <= 1'b0;
      rspTrap  <= 1'b0;
      rspOk    <= 1'b0;
    end else begin
      rspValid <= reqValid;
      rspData  <= rdWord;
      rspTag   <= curTag;
      rspTrap  <= strb.raiseTrap;
      rspOk    <= reqValid && !strb.fail;
    end
  end

endmodule

// File: rtl/fetag_mem.sv
module fetag_mem
  import fetag_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reqValid,
  input  logic [2:0]        reqOp,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  output logic              rspValid,
  output logic [DATA_W-1:0] rspData,
  output logic              rspTag,
  output logic              rspTrap,
  output logic              rspOk
);

  feStrobe_t strb;
  logic      curTag;

  fetag_ctrl u_ctrl (
    .reqValid (reqValid),
    .reqOp    (reqOp),
    .curTag   (curTag),
    .strb     (strb)
  );

  fetag_dpath #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_dpath (
    .clk      (clk),
    .rst      (rst),
    .reqValid (reqValid),
    .reqAddr  (reqAddr),
    .reqWdata (reqWdata),
    .strb     (strb),
    .curTag   (curTag),
    .rspValid (rspValid),
    .rspData  (rspData),
    .rspTag   (rspTag),
    .rspTrap  (rspTrap),
    .rspOk    (rspOk)
  );

endmodule

// File: rtl/fetag_mem_chk.sv
module fetag_mem_chk #(
  parameter int ADDR_W = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              reqValid,
  input logic [2:0]        reqOp,
  input logic [ADDR_W-1:0] reqAddr,
  input logic              rspValid,
  input logic              rspTag,
  input logic              rspTrap,
  input logic              rspOk
);

  assert_reset_idle_R1: assert property (@(posedge clk)
    rst |=> !rspValid);

  assert_rsp_follows_R2: assert property (@(posedge clk) disable iff (rst)
    reqValid |=> rspValid);

  assert_no_spurious_R2: assert property (@(posedge clk) disable iff (rst)
    !reqValid |=> !rspValid);

  assert_plain_ok_R3: assert property (@(posedge clk) disable iff (rst)
    (reqValid && reqOp[2:1] == 2'b00) |=> (rspOk && !rspTrap));

  assert_put_needs_empty_R5: assert property (@(posedge clk) disable iff (rst)
    (reqValid && (reqOp == 3'd3 || reqOp == 3'd5)) |=> (rspOk == !rspTag));

  assert_put_full_traps_R6: assert property (@(posedge clk) disable iff (rst)
    (reqValid && reqOp == 3'd3) |=> (rspTrap == rspTag));

  assert_take_needs_full_R7: assert property (@(posedge clk) disable iff (rst)
    (reqValid && (reqOp == 3'd2 || reqOp == 3'd4)) |=> (rspOk == rspTag));

  assert_chke_R9: assert property (@(posedge clk) disable iff (rst)
    (reqValid && (reqOp == 3'd6 || reqOp == 3'd7)) |=> (rspOk == !rspTag));

  assert_trap_excl_R10: assert property (@(posedge clk) disable iff (rst)
    rspTrap |-> !rspOk);

  assert_probe_notrap_R10: assert property (@(posedge clk) disable iff (rst)
    (reqValid && (reqOp == 3'd4 || reqOp == 3'd5 || reqOp == 3'd7)) |=> !rspTrap);

  assert_no_double_put_R11: assert property (@(posedge clk) disable iff (rst)
    (reqValid && reqOp == 3'd3) ##1
    (reqValid && reqOp == 3'd3 && reqAddr == $past(reqAddr)) |=> !rspOk);

endmodule

bind fetag_mem fetag_mem_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .reqValid (reqValid),
  .reqOp    (reqOp),
  .reqAddr  (reqAddr),
  .rspValid (rspValid),
  .rspTag   (rspTag),
  .rspTrap  (rspTrap),
  .rspOk    (rspOk)
);

// File: tb/fetag_mem_tb.sv
module fetag_mem_tb;

  logic        clk = 1'b0;
  logic        rst;
  logic        reqValid;
  logic [2:0]  reqOp;
  logic [3:0]  reqAddr;
  logic [15:0] reqWdata;
  logic        rspValid;
  logic [15:0] rspData;
  logic        rspTag;
  logic        rspTrap;
  logic        rspOk;

  int  nChecks = 0;
  int  nFails  = 0;
  bit  finished = 1'b0;

  always #10 clk = ~clk;   // 50 MHz

  fetag_mem u_dut (
    .clk(clk), .rst(rst), .reqValid(reqValid), .reqOp(reqOp),
    .reqAddr(reqAddr), .reqWdata(reqWdata), .rspValid(rspValid),
    .rspData(rspData), .rspTag(rspTag), .rspTrap(rspTrap), .rspOk(rspOk)
  );

  typedef struct packed {
    logic [2:0]  op;
    logic [3:0]  addr;
    logic [15:0] wd;
    logic        eTrap;
    logic        eOk;
    logic        eTag;
    logic        chkD;
    logic [15:0] eData;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 25;
  // opcodes: 0 load, 1 store, 2 take, 3 put, 4 take-probe, 5 put-probe, 6 chk-empty, 7 chk-empty-probe
  localparam vec_t VECS [NV] = '{
    '{3'd0, 4'd3, 16'h0000, 1'b0, 1'b1, 1'b0, 1'b0, 16'h0000, 4'd1},  // R1 tag empty after reset
    '{3'd1, 4'd3, 16'h1111, 1'b0, 1'b1, 1'b0, 1'b0, 16'h0000, 4'd4},  // R4 plain store
    '{3'd0, 4'd3, 16'h0000, 1'b0, 1'b1, 1'b0, 1'b1, 16'h1111, 4'd3},  // R3 load sees store
    '{3'd2, 4'd3, 16'h0000, 1'b1, 1'b0, 1'b0, 1'b1, 16'h1111, 4'd8},  // R8 take empty traps
    '{3'd4, 4'd3, 16'h0000, 1'b0, 1'b0, 1'b0, 1'b1, 16'h1111, 4'd10}, // R10 probe take fails quietly
    '{3'd3, 4'd3, 16'h2222, 1'b0, 1'b1, 1'b0, 1'b1, 16'h1111, 4'd5},  // R5 put on empty
    '{3'd0, 4'd3, 16'h0000, 1'b0, 1'b1, 1'b1, 1'b1, 16'h2222, 4'd5},  // R5 now full
    '{3'd3, 4'd3, 16'h3333, 1'b1, 1'b0, 1'b1, 1'b1, 16'h2222, 4'd6},  // R6 put on full traps
    '{3'd5, 4'd3, 16'h4444, 1'b0, 1'b0, 1'b1, 1'b1, 16'h2222, 4'd10}, // R10 probe put fails
    '{3'd0, 4'd3, 16'h0000, 1'b0, 1'b1, 1'b1, 1'b1, 16'h2222, 4'd6},  // R6 no write, still full
    '{3'd6, 4'd3, 16'h0000, 1'b1, 1'b0, 1'b1, 1'b1, 16'h2222, 4'd9},  // R9 chk-empty on full traps
    '{3'd7, 4'd3, 16'h0000, 1'b0, 1'b0, 1'b1, 1'b1, 16'h2222, 4'd10}, // R10 probe chk-empty
    '{3'd2, 4'd3, 16'h0000, 1'b0, 1'b1, 1'b1, 1'b1, 16'h2222, 4'd7},  // R7 take on full
    '{3'd0, 4'd3, 16'h0000, 1'b0, 1'b1, 1'b0, 1'b1, 16'h2222, 4'd7},  // R7 now empty
    '{3'd6, 4'd3, 16'h0000, 1'b0, 1'b1, 1'b0, 1'b1, 16'h2222, 4'd9},  // R9 chk-empty succeeds
    '{3'd0, 4'd3, 16'h0000, 1'b0, 1'b1, 1'b0, 1'b1, 16'h2222, 4'd9},  // R9 tag unchanged
    '{3'd5, 4'd5, 16'h5555, 1'b0, 1'b1, 1'b0, 1'b0, 16'h0000, 4'd10}, // R10 probe put succeeds
    '{3'd4, 4'd5, 16'h0000, 1'b0, 1'b1, 1'b1, 1'b1, 16'h5555, 4'd10}, // R10 probe take succeeds
    '{3'd0, 4'd5, 16'h0000, 1'b0, 1'b1, 1'b0, 1'b1, 16'h5555, 4'd12}, // R12 pre-access values
    '{3'd3, 4'd3, 16'h7777, 1'b0, 1'b1, 1'b0, 1'b1, 16'h2222, 4'd11}, // R11 first put wins
    '{3'd3, 4'd3, 16'h9999, 1'b1, 1'b0, 1'b1, 1'b1, 16'h7777, 4'd11}, // R11 second put sees full
    '{3'd1, 4'd3, 16'h8888, 1'b0, 1'b1, 1'b1, 1'b1, 16'h7777, 4'd4},  // R4 store on full word
    '{3'd0, 4'd3, 16'h0000, 1'b0, 1'b1, 1'b1, 1'b1, 16'h8888, 4'd4},  // R4 tag kept full
    '{3'd0, 4'd5, 16'h0000, 1'b0, 1'b1, 1'b0, 1'b1, 16'h5555, 4'd3},  // R3 other word untouched
    '{3'd0, 4'd5, 16'h0000, 1'b0, 1'b1, 1'b0, 1'b1, 16'h5555, 4'd3}   // R3 load changes nothing
  };

  task automatic checkBit(string req, string what, logic act, logic exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s %s actual=%0b expected=%0b", req, what, act, exp);
    end
  endtask

  task automatic checkRsp(string req, logic eTrap, logic eOk, logic eTag,
                          logic chkD, logic [15:0] eData);
    nChecks++;
    if (rspValid !== 1'b1 || rspTrap !== eTrap || rspOk !== eOk || rspTag !== eTag ||
        (chkD && rspData !== eData)) begin
      nFails++;
      $display("FAIL %s actual v=%0b trap=%0b ok=%0b tag=%0b data=%h expected v=1 trap=%0b ok=%0b tag=%0b data=%h",
               req, rspValid, rspTrap, rspOk, rspTag, rspData, eTrap, eOk, eTag, eData);
    end
  endtask

  task automatic drive(logic [2:0] op, logic [3:0] addr, logic [15:0] wd);
    reqValid = 1'b1;
    reqOp    = op;
    reqAddr  = addr;
    reqWdata = wd;
  endtask

  task automatic idle();
    reqValid = 1'b0;
    reqOp    = 3'd0;
    reqAddr  = '0;
    reqWdata = '0;
  endtask

  initial begin
    rst = 1'b1;
    idle();
    repeat (3) @(posedge clk);
    @(negedge clk);
    checkBit("R1", "rspValid in reset", rspValid, 1'b0);
    rst = 1'b0;
    @(negedge clk);
    checkBit("R2", "rspValid idle", rspValid, 1'b0);

    // table walk, back-to-back requests
    for (int i = 0; i < NV; i++) begin
      drive(VECS[i].op, VECS[i].addr, VECS[i].wd);
      @(negedge clk);
      checkRsp($sformatf("R%0d vec%0d", VECS[i].req, i), VECS[i].eTrap, VECS[i].eOk,
               VECS[i].eTag, VECS[i].chkD, VECS[i].eData);
    end
    idle();
    @(negedge clk);
    checkBit("R2", "rspValid after idle", rspValid, 1'b0);

    // highest address: put then take
    drive(3'd3, 4'd15, 16'hABCD);
    @(negedge clk);
    checkRsp("R5 addr15", 1'b0, 1'b1, 1'b0, 1'b0, 16'h0);
    drive(3'd2, 4'd15, 16'h0);
    @(negedge clk);
    checkRsp("R7 addr15", 1'b0, 1'b1, 1'b1, 1'b1, 16'hABCD);
    drive(3'd2, 4'd15, 16'h0);
    @(negedge clk);
    checkRsp("R8 addr15", 1'b1, 1'b0, 1'b0, 1'b1, 16'hABCD);

    // reset while word 3 is full clears the tag
    idle();
    rst = 1'b1;
    @(negedge clk);
    checkBit("R1", "rspValid mid reset", rspValid, 1'b0);
    rst = 1'b0;
    drive(3'd0, 4'd3, 16'h0);
    @(negedge clk);
    checkRsp("R1 tag cleared", 1'b0, 1'b1, 1'b0, 1'b0, 16'h0);
    drive(3'd3, 4'd3, 16'h1234);
    @(negedge clk);
    checkRsp("R5 put after reset", 1'b0, 1'b1, 1'b0, 1'b0, 16'h0);
    idle();
    @(negedge clk);

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      nFails++;
      $display("FAIL R2 watchdog actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

endmodule